// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a display: horizontal sync, vertical sync, a composite sync and a blank signal, plus one-cycle strobes that mark the start of each line and each frame. All of them are derived from two counters running on the pixel clock. The horizontal counter advances every enabled clock. The vertical counter advances once per completed line.

Each axis is described by four numbers: a sync width, a delay between the end of sync and the start of the visible area, a visible length, and a total length. All four are coded as "value minus one". The horizontal and vertical sync/delay/visible triples arrive as two packed words, and the two totals share a third word. A separate shadow copy of these words is taken while the generator is stopped and again at the last clock of every frame. The raster geometry can therefore be rewritten at any time without tearing a frame. Each of the four level outputs has its own inversion bit. A downstream pixel fetcher starts a frame on the frame strobe and treats pixels as valid only while blank is deasserted.

Top module: `vtg_top`

## Requirements
- R1: While `rst` is high, or on the clock after `en` is sampled low, the outputs are at their idle levels. The sync outputs equal their polarity bits, `blank_o` equals the inverse of `bpol`, and both strobes are 0. Both counters are held at zero.
- R2: Within a line, horizontal sync is active for the first S+1 clocks, where S is bits 31:24 of `htim_i`.
- R3: After horizontal sync come D+1 delay clocks, where D is bits 23:16 of `htim_i`. After the delay come G+1 visible clocks, where G is bits 15:0 of `htim_i`.
- R4: A line lasts HT+1 clocks, where HT is bits 31:16 of `len_i`. `line_start_o` is high for the first clock of every line.
- R5: The vertical axis runs the same sequence counted in lines, using `vtim_i` (same field layout as `htim_i`) and VT = bits 15:0 of `len_i`. A frame is VT+1 lines.
- R6: The active-high blank is deasserted only when both axes are in their visible window.
- R7: The active-high composite sync is the XOR of the active-high horizontal and vertical sync levels, taken before any polarity is applied.
- R8: A 1 in `hpol`, `vpol`, `cpol` or `bpol` inverts the corresponding output.
- R9: `frame_start_o` is high for the first clock of the first line of every frame only.
- R10: Timing words are sampled while stopped and at the last clock of a frame. A change made mid-frame takes effect from the next frame.
- R11: All outputs are registered. An output after clock edge k reflects the counter position held before edge k. After `en` rises, the first edge produces line 0, clock 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low stops and clears the raster |
| hpol | input | 1 | Invert horizontal sync |
| vpol | input | 1 | Invert vertical sync |
| cpol | input | 1 | Invert composite sync |
| bpol | input | 1 | Invert blank |
| htim_i | input | 32 | Horizontal {sync, delay, visible} word |
| vtim_i | input | 32 | Vertical {sync, delay, visible} word |
| len_i | input | 32 | {horizontal total, vertical total} |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| csync_o | output | 1 | Composite sync |
| blank_o | output | 1 | Blank |
| line_start_o | output | 1 | First clock of each line |
| frame_start_o | output | 1 | First clock of each frame |

## Verification
The bench targets the phase boundaries of the counters.

- **Off-by-one in the "minus one" coding.** A raster with no idle clocks, where the visible area ends on the final count, exposes this error: a design with it shows a visible area one pixel short or long, or a line one clock off.
- **Mid-frame parameter writes.** A design that loses the frame-boundary sampling tears the current frame, because its sync and blank edges move immediately.
- **Stop and restart.** A design that keeps counting while stopped restarts at a position other than line 0, clock 0.
- **Polarity and composite sync.** Inverting all outputs and using a vertical sync wider than one line catches a composite sync formed after inversion instead of before.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  // Position of a counter within its axis sequence.
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_DELAY = 2'd1,
    PH_VIS   = 2'd2,
    PH_IDLE  = 2'd3
  } phase_t;
endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow #(
  parameter int SW = 8,
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [2*SW+GW-1:0] htim_i,
  input  logic [2*SW+GW-1:0] vtim_i,
  input  logic [2*GW-1:0]    len_i,
  output logic [SW-1:0] sync_q [2],
  output logic [SW-1:0] gdel_q [2],
  output logic [GW-1:0] gate_q [2],
  output logic [GW-1:0] tot_q  [2]
);
  localparam int TW = 2*SW + GW;

  logic [TW-1:0] tim_w [2];
  assign tim_w[0] = htim_i;
  assign tim_w[1] = vtim_i;

  // Index 0 is horizontal, 1 is vertical; totals sit high then low in len_i.
  for (genvar a = 0; a < 2; a++) begin : g_axis
    always_ff @(posedge clk) begin
      if (rst || load) begin
        sync_q[a] <= tim_w[a][TW-1 -: SW];
        gdel_q[a] <= tim_w[a][GW+SW-1 -: SW];
        gate_q[a] <= tim_w[a][GW-1:0];
        tot_q[a]  <= len_i[(2-a)*GW-1 -: GW];
      end
    end
  end
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
  import vtg_pkg::*;
#(
  parameter int SW = 8,
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          step,
  input  logic [SW-1:0] sync_w,
  input  logic [SW-1:0] gdel,
  input  logic [GW-1:0] gate,
  input  logic [GW-1:0] total,
  output logic [GW-1:0] cnt,
  output logic          last,
  output phase_t        phase
);
  localparam int EW = GW + 2;

  logic [EW-1:0] cnt_e, sync_e, vis_lo, vis_hi;

  assign cnt_e  = EW'(cnt);
  assign sync_e = EW'(sync_w);
  assign vis_lo = EW'(sync_w) + EW'(gdel) + EW'(2);
  assign vis_hi = vis_lo + EW'(gate);
  assign last   = (cnt == total);

  always_comb begin
    if (cnt_e <= sync_e)     phase = PH_SYNC;
    else if (cnt_e < vis_lo) phase = PH_DELAY;
    else if (cnt_e <= vis_hi) phase = PH_VIS;
    else                     phase = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (step)     cnt <= last ? '0 : cnt + GW'(1);
  end
endmodule

// File: rtl/vtg_outreg.sv
module vtg_outreg
  import vtg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  logic   hpol,
  input  logic   vpol,
  input  logic   cpol,
  input  logic   bpol,
  input  phase_t h_phase,
  input  phase_t v_phase,
  input  logic   h_zero,
  input  logic   v_zero,
  output logic   hsync_o,
  output logic   vsync_o,
  output logic   csync_o,
  output logic   blank_o,
  output logic   line_start_o,
  output logic   frame_start_o
);
  logic hs_raw, vs_raw, bl_raw;

  assign hs_raw = (h_phase == PH_SYNC);
  assign vs_raw = (v_phase == PH_SYNC);
  assign bl_raw = !((h_phase == PH_VIS) && (v_phase == PH_VIS));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hsync_o       <= hpol;
      vsync_o       <= vpol;
      csync_o       <= cpol;
      blank_o       <= !bpol;
      line_start_o  <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      hsync_o       <= hs_raw ^ hpol;
      vsync_o       <= vs_raw ^ vpol;
      csync_o       <= (hs_raw ^ vs_raw) ^ cpol;
      blank_o       <= bl_raw ^ bpol;
      line_start_o  <= h_zero;
      frame_start_o <= h_zero && v_zero;
    end
  end
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int SW = 8,
  parameter int GW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              hpol,
  input  logic              vpol,
  input  logic              cpol,
  input  logic              bpol,
  input  logic [2*SW+GW-1:0] htim_i,
  input  logic [2*SW+GW-1:0] vtim_i,
  input  logic [2*GW-1:0]    len_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              csync_o,
  output logic              blank_o,
  output logic              line_start_o,
  output logic              frame_start_o
);
  logic [SW-1:0] sync_q [2];
  logic [SW-1:0] gdel_q [2];
  logic [GW-1:0] gate_q [2];
  logic [GW-1:0] tot_q  [2];
  logic [GW-1:0] cnt_a  [2];
  logic          last_a [2];
  phase_t        ph_a   [2];
  logic          step_a [2];
  logic          frame_end;
  logic [GW-1:0] h_cnt, v_cnt, h_tot, v_tot;

  assign step_a[0] = 1'b1;
  assign step_a[1] = last_a[0];
  assign frame_end = last_a[0] && last_a[1];
  assign h_cnt = cnt_a[0];
  assign v_cnt = cnt_a[1];
  assign h_tot = tot_q[0];
  assign v_tot = tot_q[1];

  vtg_shadow #(.SW(SW), .GW(GW)) u_shadow (
    .clk(clk), .rst(rst), .load(!en || frame_end),
    .htim_i(htim_i), .vtim_i(vtim_i), .len_i(len_i),
    .sync_q(sync_q), .gdel_q(gdel_q), .gate_q(gate_q), .tot_q(tot_q)
  );

  for (genvar a = 0; a < 2; a++) begin : g_axis
    vtg_axis #(.SW(SW), .GW(GW)) u_axis (
      .clk(clk), .rst(rst), .run(en), .step(step_a[a]),
      .sync_w(sync_q[a]), .gdel(gdel_q[a]), .gate(gate_q[a]), .total(tot_q[a]),
      .cnt(cnt_a[a]), .last(last_a[a]), .phase(ph_a[a])
    );
  end

  vtg_outreg u_out (
    .clk(clk), .rst(rst), .en(en),
    .hpol(hpol), .vpol(vpol), .cpol(cpol), .bpol(bpol),
    .h_phase(ph_a[0]), .v_phase(ph_a[1]),
    .h_zero(cnt_a[0] == '0), .v_zero(cnt_a[1] == '0),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .csync_o(csync_o), .blank_o(blank_o),
    .line_start_o(line_start_o), .frame_start_o(frame_start_o)
  );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int GW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          hpol,
  input logic          vpol,
  input logic          cpol,
  input logic          bpol,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          csync_o,
  input logic          blank_o,
  input logic          line_start_o,
  input logic          frame_start_o,
  input logic [GW-1:0] h_cnt,
  input logic [GW-1:0] h_tot,
  input logic [GW-1:0] v_cnt,
  input logic [GW-1:0] v_tot
);
  a_r1_stop_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> (hsync_o == $past(hpol)) && (vsync_o == $past(vpol)) &&
            (blank_o != $past(bpol)) && !line_start_o && !frame_start_o);

  a_r7_csync_xor: assert property (@(posedge clk) disable iff (rst)
    (csync_o ^ $past(cpol)) == ((hsync_o ^ $past(hpol)) ^ (vsync_o ^ $past(vpol))));

  a_r9_frame_in_line: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> line_start_o && (vsync_o != $past(vpol)));

  a_r2_line_opens_sync: assert property (@(posedge clk) disable iff (rst)
    line_start_o |-> (hsync_o != $past(hpol)));

  a_r6_blank_in_sync: assert property (@(posedge clk) disable iff (rst)
    (hsync_o != $past(hpol)) |-> (blank_o != $past(bpol)));

  a_r4_hcnt_bound: assert property (@(posedge clk) disable iff (rst)
    h_cnt <= h_tot);

  a_r5_vcnt_bound: assert property (@(posedge clk) disable iff (rst)
    v_cnt <= v_tot);
endmodule

bind vtg_top vtg_checker #(.GW(GW)) u_chk (
  .clk(clk), .rst(rst), .en(en),
  .hpol(hpol), .vpol(vpol), .cpol(cpol), .bpol(bpol),
  .hsync_o(hsync_o), .vsync_o(vsync_o), .csync_o(csync_o), .blank_o(blank_o),
  .line_start_o(line_start_o), .frame_start_o(frame_start_o),
  .h_cnt(h_cnt), .h_tot(h_tot), .v_cnt(v_cnt), .v_tot(v_tot)
);

// File: tb/vtg_top_tb.sv
module vtg_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic hpol = 1'b0, vpol = 1'b0, cpol = 1'b0, bpol = 1'b0;
  logic [31:0] htim = '0, vtim = '0, lens = '0;
  logic hsync, vsync, csync, blank, lstart, fstart;

  int checks = 0;
  int fails = 0;

  // Reference raster position and parameters in force
  int mh = 0, mv = 0;
  int a_hs, a_hg, a_hgt, a_ht, a_vs, a_vg, a_vgt, a_vt;

  always #10 clk = ~clk;

  vtg_top u_dut (
    .clk(clk), .rst(rst), .en(en),
    .hpol(hpol), .vpol(vpol), .cpol(cpol), .bpol(bpol),
    .htim_i(htim), .vtim_i(vtim), .len_i(lens),
    .hsync_o(hsync), .vsync_o(vsync), .csync_o(csync), .blank_o(blank),
    .line_start_o(lstart), .frame_start_o(fstart)
  );

  task automatic check(input string req, input string sig, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, sig, act, exp, $time);
    end
  endtask

  task automatic set_par(input int hs, hg, hgt, ht, vs, vg, vgt, vt);
    htim = {hs[7:0], hg[7:0], hgt[15:0]};
    vtim = {vs[7:0], vg[7:0], vgt[15:0]};
    lens = {ht[15:0], vt[15:0]};
  endtask

  // One clock: snapshot inputs at the edge, predict, advance model, compare at negedge.
  task automatic cyc(input string req);
    logic s_en, s_rst, s_hp, s_vp, s_cp, s_bp;
    logic e_hs, e_vs, e_cs, e_bl, e_ls, e_fs, sh, sv, hvis, vvis;
    int lo;
    @(posedge clk);
    s_en = en; s_rst = rst; s_hp = hpol; s_vp = vpol; s_cp = cpol; s_bp = bpol;
    if (s_rst || !s_en) begin
      e_hs = s_hp; e_vs = s_vp; e_cs = s_cp; e_bl = !s_bp; e_ls = 0; e_fs = 0;
      mh = 0; mv = 0;
      a_hs = htim[31:24]; a_hg = htim[23:16]; a_hgt = htim[15:0]; a_ht = lens[31:16];
      a_vs = vtim[31:24]; a_vg = vtim[23:16]; a_vgt = vtim[15:0]; a_vt = lens[15:0];
    end else begin
      sh = (mh <= a_hs);
      sv = (mv <= a_vs);
      lo = a_hs + a_hg + 2;
      hvis = (mh >= lo) && (mh <= lo + a_hgt);
      lo = a_vs + a_vg + 2;
      vvis = (mv >= lo) && (mv <= lo + a_vgt);
      e_hs = sh ^ s_hp; e_vs = sv ^ s_vp; e_cs = (sh ^ sv) ^ s_cp;
      e_bl = !(hvis && vvis) ^ s_bp;
      e_ls = (mh == 0); e_fs = (mh == 0) && (mv == 0);
      if (mh == a_ht) begin
        mh = 0;
        if (mv == a_vt) begin
          mv = 0;
          a_hs = htim[31:24]; a_hg = htim[23:16]; a_hgt = htim[15:0]; a_ht = lens[31:16];
          a_vs = vtim[31:24]; a_vg = vtim[23:16]; a_vgt = vtim[15:0]; a_vt = lens[15:0];
        end else mv++;
      end else mh++;
    end
    @(negedge clk);
    check({req, "/R2"}, "hsync", hsync, e_hs);
    check({req, "/R5"}, "vsync", vsync, e_vs);
    check({req, "/R7"}, "csync", csync, e_cs);
    check({req, "/R6"}, "blank", blank, e_bl);
    check({req, "/R4"}, "line_start", lstart, e_ls);
    check({req, "/R9"}, "frame_start", fstart, e_fs);
  endtask

  task automatic t_reset();
    set_par(1, 0, 3, 9, 0, 0, 1, 4);
    for (int i = 0; i < 4; i++) cyc("R1");
    rst = 1'b0;
    for (int i = 0; i < 3; i++) cyc("R1");
  endtask

  task automatic t_basic();
    en = 1'b1;
    for (int i = 0; i < 100; i++) cyc("R3");
    en = 1'b0;
    for (int i = 0; i < 3; i++) cyc("R1");
  endtask

  task automatic t_polarity();
    hpol = 1; vpol = 1; cpol = 1; bpol = 1;
    set_par(2, 3, 4, 14, 1, 1, 2, 7);
    for (int i = 0; i < 3; i++) cyc("R8");
    en = 1'b1;
    for (int i = 0; i < 120; i++) cyc("R8");
    en = 1'b0;
    hpol = 0; vpol = 0; cpol = 0; bpol = 0;
    for (int i = 0; i < 3; i++) cyc("R1");
  endtask

  task automatic t_reload();
    set_par(1, 0, 3, 9, 0, 0, 1, 4);
    for (int i = 0; i < 2; i++) cyc("R10");
    en = 1'b1;
    for (int i = 0; i < 17; i++) cyc("R10");
    set_par(0, 1, 2, 7, 1, 0, 0, 3);
    for (int i = 0; i < 33 + 32 + 10; i++) cyc("R10");
    en = 1'b0;
    for (int i = 0; i < 3; i++) cyc("R1");
  endtask

  task automatic t_restart();
    set_par(1, 1, 2, 8, 0, 1, 1, 5);
    for (int i = 0; i < 2; i++) cyc("R11");
    en = 1'b1;
    for (int i = 0; i < 23; i++) cyc("R11");
    en = 1'b0;
    for (int i = 0; i < 5; i++) cyc("R1");
    en = 1'b1;
    for (int i = 0; i < 60; i++) cyc("R11");
    en = 1'b0;
    for (int i = 0; i < 3; i++) cyc("R1");
  endtask

  task automatic t_tight();
    // No idle clocks: the visible area ends on the final count of each axis.
    set_par(0, 0, 2, 4, 0, 0, 1, 3);
    for (int i = 0; i < 2; i++) cyc("R3");
    en = 1'b1;
    for (int i = 0; i < 45; i++) cyc("R3");
    en = 1'b0;
    for (int i = 0; i < 2; i++) cyc("R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_polarity();
    t_reload();
    t_restart();
    t_tight();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule